// File: doc/BRIEF.md
# Frequency-Window Lock Detector

This block decides whether a feedback clock runs at roughly the same rate as a reference clock and raises a coarse lock flag when it does. Both clocks arrive asynchronously and are brought into a faster system clock domain, where only their rising edges are used. The reference clock sets the pace: every 32 reference cycles the block runs one measurement. It counts feedback rising edges over the first 14 reference cycles of that period, reports the count, and updates the lock flag.

The flag has hysteresis. To acquire lock, the count must fall in a narrow band around the nominal value of 14. To lose lock once held, the count must leave a wider band. No evaluation takes place unless reference edges arrive. If the reference stops, the flag and the reported count keep the values from the last measurement. The system clock must run at least four times faster than either input clock.

Top module: `freq_lock_detector`

## Requirements
- R1: Synchronous active-low reset sets `lock_flag` to 0 and `meas_count` to 0. After reset is released, the first reference rising edge starts a new measurement period.
- R2: A measurement counts the feedback rising edges that fall between the 1st and the 15th reference rising edge of a period, which spans 14 reference cycles. The result appears on `meas_count` when the 15th edge is seen.
- R3: Measurement periods are 32 reference cycles long. `lock_flag` and `meas_count` change only at the close of a measurement window and stay stable between closes, even when the feedback rate changes.
- R4: While unlocked, the flag goes to 1 at a window close only if the count is 13, 14 or 15. With counts such as 12 or 16 it stays 0.
- R5: While locked, the flag drops to 0 at a window close if the count is below 11 or above 17. With counts from 11 to 17 it stays 1.
- R6: While the reference clock is stopped, neither `lock_flag` nor `meas_count` changes, whatever the feedback clock does.
- R7: The feedback count saturates at 31 and never wraps. A feedback clock far too fast reports 31 and cannot be accepted as lock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 4x faster than either monitored clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ref_clk_in | input | 1 | Reference clock, asynchronous to `clk` |
| fb_clk_in | input | 1 | Feedback clock under test, asynchronous to `clk` |
| lock_flag | output | 1 | Coarse lock indication with hysteresis |
| meas_count | output | 5 | Feedback edge count from the most recent window |

## Verification
The bench builds the block with its default parameters: a 32-cycle period, a 14-cycle window, an acquire band of 13 to 15, a hold band of 11 to 17, and saturation at 31. The reference clock has a 200 ns period. The feedback period is set to 2800/N ns, so each window holds exactly N feedback edges. This lets the bench hit every band edge directly (10, 11, 12, 13, 15, 16, 17, 18). An 80 ns feedback clock gives 35 edges per window, which drives the counter into saturation. Feedback changes are placed after a window closes, so each check sees a window that is entirely at the new rate, and the 32-cycle spacing between decisions can be checked.

// File: rtl/lockdet_pkg.sv
`timescale 1ns/1ps
// Shared types and helpers for the frequency-window lock detector.
package lockdet_pkg;

    // State of the hysteresis decision.
    typedef enum logic {
        LK_SEARCH = 1'b0,
        LK_HELD   = 1'b1
    } lock_state_e;

    // True when v lies within the closed range [lo, hi].
    function automatic logic in_range(input int unsigned v,
                                      input int unsigned lo,
                                      input int unsigned hi);
        return (v >= lo) && (v <= hi);
    endfunction

endpackage

// File: rtl/lockdet_edge_sync.sv
`timescale 1ns/1ps
// Brings an asynchronous clock signal into the clk domain through a
// flop chain and emits a one-cycle pulse for each rising edge.
// Assumes clk samples each level of async_in at least once, i.e. clk
// runs at least 4x faster than the monitored clock.
module lockdet_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise_pulse
);

    logic [STAGES-1:0] chain;
    logic              last_q;

    // Synchronizer chain: stage 0 samples the raw input.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain <= '0;
        end else begin
            chain[0] <= async_in;
            for (int i = 1; i < STAGES; i++) begin
                chain[i] <= chain[i-1];
            end
        end
    end

    // Delayed copy of the synchronized level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_q <= 1'b0;
        end else begin
            last_q <= chain[STAGES-1];
        end
    end

    assign rise_pulse = chain[STAGES-1] & ~last_q;

endmodule

// File: rtl/lockdet_window_seq.sv
`timescale 1ns/1ps
// Tracks the position within a measurement period, in reference edges.
// Position 0 exists only after reset. The reference edge seen at
// position 0 or PERIOD starts a period (position becomes 1). The window
// is open for positions 1..WIN and closes on the reference edge seen at
// position WIN, so it spans WIN reference cycles.
// Assumes 1 <= WIN < PERIOD.
module lockdet_window_seq #(
    parameter int PERIOD = 32,
    parameter int WIN    = 14
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_pulse,
    output logic win_start,
    output logic win_open,
    output logic win_close
);

    localparam int PH_W = $clog2(PERIOD + 1);

    logic [PH_W-1:0] phase_q;

    assign win_start = ref_pulse && ((phase_q == '0) || (phase_q == PH_W'(PERIOD)));
    assign win_close = ref_pulse && (phase_q == PH_W'(WIN));
    assign win_open  = (phase_q != '0) && (phase_q <= PH_W'(WIN));

    // Advance the period position on every reference edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= '0;
        end else if (win_start) begin
            phase_q <= PH_W'(1);
        end else if (ref_pulse) begin
            phase_q <= phase_q + PH_W'(1);
        end
    end

endmodule

// File: rtl/lockdet_sat_counter.sv
`timescale 1ns/1ps
// Saturating event counter. On clear it loads 1 or 0, depending on
// whether an event arrives in the same cycle. Otherwise it increments
// on inc and holds at SAT_MAX.
// Assumes SAT_MAX fits in CNT_W bits.
module lockdet_sat_counter #(
    parameter int SAT_MAX = 31,
    parameter int CNT_W   = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             load_one,
    input  logic             inc,
    output logic [CNT_W-1:0] count
);

    // Count events, restarting on clear and sticking at the ceiling.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (clear) begin
            count <= load_one ? CNT_W'(1) : '0;
        end else if (inc && (count != CNT_W'(SAT_MAX))) begin
            count <= count + CNT_W'(1);
        end
    end

endmodule

// File: rtl/lockdet_hysteresis.sv
`timescale 1ns/1ps
// Lock decision with separate acquire and hold bands. On each decide
// pulse it captures the sample and moves between searching and held.
// Assumes the acquire band lies inside the hold band.
module lockdet_hysteresis
    import lockdet_pkg::*;
#(
    parameter int CNT_W   = 5,
    parameter int ACQ_LO  = 13,
    parameter int ACQ_HI  = 15,
    parameter int HOLD_LO = 11,
    parameter int HOLD_HI = 17
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             decide,
    input  logic [CNT_W-1:0] sample,
    output logic             lock_flag,
    output logic [CNT_W-1:0] last_count
);

    lock_state_e state_q, state_nx;

    // Next-state rule: narrow band to enter lock, wide band to stay.
    always_comb begin
        state_nx = state_q;
        if (decide) begin
            unique case (state_q)
                LK_SEARCH: if (in_range(32'(sample), ACQ_LO, ACQ_HI))
                               state_nx = LK_HELD;
                LK_HELD:   if (!in_range(32'(sample), HOLD_LO, HOLD_HI))
                               state_nx = LK_SEARCH;
                default:   state_nx = LK_SEARCH;
            endcase
        end
    end

    // Register the decision and the count it was based on.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= LK_SEARCH;
            last_count <= '0;
        end else begin
            state_q <= state_nx;
            if (decide) begin
                last_count <= sample;
            end
        end
    end

    assign lock_flag = (state_q == LK_HELD);

endmodule

// File: rtl/freq_lock_detector.sv
`timescale 1ns/1ps
// Frequency-window lock detector. It counts feedback edges over the
// first WIN reference cycles of every PERIOD-cycle period and updates a
// coarse lock flag with hysteresis. Both monitored clocks are sampled by
// clk, which must be at least 4x faster than either of them. Without
// reference edges no evaluation happens, so the outputs keep their values.
module freq_lock_detector #(
    parameter  int PERIOD      = 32,
    parameter  int WIN         = 14,
    parameter  int ACQ_LO      = 13,
    parameter  int ACQ_HI      = 15,
    parameter  int HOLD_LO     = 11,
    parameter  int HOLD_HI     = 17,
    parameter  int SAT_MAX     = 31,
    parameter  int SYNC_STAGES = 2,
    localparam int CNT_W       = $clog2(SAT_MAX + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ref_clk_in,
    input  logic             fb_clk_in,
    output logic             lock_flag,
    output logic [CNT_W-1:0] meas_count
);

    localparam int N_CLK = 2;   // index 0: reference, index 1: feedback

    logic [N_CLK-1:0] raw_clk;
    logic [N_CLK-1:0] rise;
    logic             ref_pulse, fb_pulse;
    logic             win_start, win_open, win_close;
    logic [CNT_W-1:0] fb_cnt;

    assign raw_clk = {fb_clk_in, ref_clk_in};

    // One synchronizer and edge detector per monitored clock.
    for (genvar g = 0; g < N_CLK; g++) begin : g_sync
        lockdet_edge_sync #(
            .STAGES (SYNC_STAGES)
        ) u_sync (
            .clk        (clk),
            .rst_n      (rst_n),
            .async_in   (raw_clk[g]),
            .rise_pulse (rise[g])
        );
    end

    assign ref_pulse = rise[0];
    assign fb_pulse  = rise[1];

    lockdet_window_seq #(
        .PERIOD (PERIOD),
        .WIN    (WIN)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .ref_pulse (ref_pulse),
        .win_start (win_start),
        .win_open  (win_open),
        .win_close (win_close)
    );

    lockdet_sat_counter #(
        .SAT_MAX (SAT_MAX),
        .CNT_W   (CNT_W)
    ) u_fbcnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (win_start),
        .load_one (fb_pulse),
        .inc      (fb_pulse && win_open && !win_close),
        .count    (fb_cnt)
    );

    lockdet_hysteresis #(
        .CNT_W   (CNT_W),
        .ACQ_LO  (ACQ_LO),
        .ACQ_HI  (ACQ_HI),
        .HOLD_LO (HOLD_LO),
        .HOLD_HI (HOLD_HI)
    ) u_decide (
        .clk        (clk),
        .rst_n      (rst_n),
        .decide     (win_close),
        .sample     (fb_cnt),
        .lock_flag  (lock_flag),
        .last_count (meas_count)
    );

endmodule

// File: rtl/lockdet_checker.sv
`timescale 1ns/1ps
// Temporal checks for freq_lock_detector, attached through bind.
// Relates the outputs to the window-close and window-start events and
// to the running feedback count.
module lockdet_checker #(
    parameter int CNT_W   = 5,
    parameter int ACQ_LO  = 13,
    parameter int ACQ_HI  = 15,
    parameter int HOLD_LO = 11,
    parameter int HOLD_HI = 17
) (
    input logic             clk,
    input logic             rst_n,
    input logic             lock_flag,
    input logic [CNT_W-1:0] meas_count,
    input logic             win_start,
    input logic             win_close,
    input logic [CNT_W-1:0] fb_cnt
);

    // R3: outputs move only in the cycle after a window close.
    assert_outputs_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(win_close) |-> ($stable(lock_flag) && $stable(meas_count)));

    // R4: entering lock requires a count inside the acquire band.
    assert_acquire_band_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_flag && !$past(lock_flag)) |->
        ((meas_count >= CNT_W'(ACQ_LO)) && (meas_count <= CNT_W'(ACQ_HI))));

    // R5: leaving lock requires a count outside the hold band.
    assert_drop_outside_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!lock_flag && $past(lock_flag)) |->
        ((meas_count < CNT_W'(HOLD_LO)) || (meas_count > CNT_W'(HOLD_HI))));

    // R5: a held lock survives any count inside the hold band.
    assert_hold_keeps_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(win_close) && $past(lock_flag) &&
         (meas_count >= CNT_W'(HOLD_LO)) && (meas_count <= CNT_W'(HOLD_HI))) |-> lock_flag);

    // R7: the feedback count falls only when a new window starts.
    assert_no_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (fb_cnt < $past(fb_cnt)) |-> $past(win_start));

    // R2: a fresh window starts from at most one edge.
    assert_window_restart_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(win_start) |-> (fb_cnt <= CNT_W'(1)));

endmodule

bind freq_lock_detector lockdet_checker #(
    .CNT_W   (CNT_W),
    .ACQ_LO  (ACQ_LO),
    .ACQ_HI  (ACQ_HI),
    .HOLD_LO (HOLD_LO),
    .HOLD_HI (HOLD_HI)
) i_lockdet_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .lock_flag  (lock_flag),
    .meas_count (meas_count),
    .win_start  (win_start),
    .win_close  (win_close),
    .fb_cnt     (fb_cnt)
);

// File: tb/test_freq_lock_detector.sv
`timescale 1ns/1ps
// Directed bench: reference period 200 ns, feedback period 2800/N ns,
// so every 14-cycle window holds exactly N feedback edges.
module test_freq_lock_detector;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ref_clk = 1'b0;
    logic       fb_clk = 1'b0;
    logic       lock_flag;
    logic [4:0] meas_count;

    int  checks = 0;
    int  errors = 0;
    bit  ref_on = 1'b1;
    real fb_t0 = 1.0e9;
    real fb_half = 100.0;
    int  fb_k = 0;
    real e_t = 0.0;        // time of the first reference edge after reset

    freq_lock_detector i_freq_lock_detector (
        .clk        (clk),
        .rst_n      (rst_n),
        .ref_clk_in (ref_clk),
        .fb_clk_in  (fb_clk),
        .lock_flag  (lock_flag),
        .meas_count (meas_count)
    );

    // 50 MHz system clock.
    always #10 clk = ~clk;

    // Reference: rises at 3 + 200k ns while enabled.
    initial begin
        #3;
        forever begin
            ref_clk = ref_on;
            #100;
            ref_clk = 1'b0;
            #100;
        end
    end

    // Feedback: edges placed at absolute times, so no drift accumulates.
    initial begin
        forever begin
            real tn;
            real d;
            tn = fb_t0 + fb_k * fb_half;
            if (tn > $realtime) begin
                d = tn - $realtime;
                if (d > 20.0) d = 20.0;
                #(d);
            end
            if ($realtime + 0.001 >= fb_t0 + fb_k * fb_half) begin
                fb_clk = (fb_k % 2 == 0);
                fb_k++;
            end
        end
    end

    task automatic check(input string req, input int act, input int exp, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Switch the feedback to N edges per 2800 ns, aligned off the sampling grid.
    task automatic fb_set(input int n);
        @(negedge clk);
        fb_clk  = 1'b0;
        fb_half = 1400.0 / n;
        fb_k    = 0;
        fb_t0   = $realtime + 7.3;
    endtask

    task automatic wait_rel(input real off);
        #(e_t + off - $realtime);
    endtask

    // Reset with the feedback at rate n. Release happens while ref is low.
    task automatic start_run(input int n);
        real tgt;
        ref_on = 1'b1;
        rst_n  = 1'b0;
        fb_set(n);
        repeat (3) @(negedge clk);
        tgt = 200.0 * ($floor($realtime / 200.0) + 1.0) + 140.0;
        #(tgt - $realtime);
        rst_n = 1'b1;
        e_t = tgt + 63.0;
    endtask

    // R1, R2, R3: reset values, no update before close, first result.
    task automatic t_reset_and_first();
        start_run(14);
        @(negedge clk);
        check("R1", lock_flag, 0, "flag after reset");
        check("R1", meas_count, 0, "count after reset");
        wait_rel(2757.0);
        check("R3", lock_flag, 0, "flag before first close");
        check("R3", meas_count, 0, "count before first close");
        wait_rel(2957.0);
        check("R2", meas_count, 14, "first window count");
        check("R4", lock_flag, 1, "acquire at 14");
    endtask

    // R3: next decision comes 32 reference cycles later, not earlier.
    task automatic t_refresh_period();
        fb_set(20);
        wait_rel(6357.0);
        check("R3", meas_count, 14, "count held until next window");
        check("R3", lock_flag, 1, "flag held until next window");
        wait_rel(9357.0);
        check("R3", meas_count, 20, "count of second window");
        check("R5", lock_flag, 0, "drop at 20");
    endtask

    // R4: acquire band edges from the unlocked state.
    task automatic t_acquire(input int n, input int exp_flag);
        start_run(n);
        wait_rel(2957.0);
        check("R2", meas_count, n, $sformatf("count for n=%0d", n));
        check("R4", lock_flag, exp_flag, $sformatf("acquire n=%0d", n));
    endtask

    // R5: hold band edges from the locked state.
    task automatic t_hold(input int n, input int exp_flag);
        start_run(14);
        wait_rel(2957.0);
        check("R4", lock_flag, 1, "lock before hold test");
        fb_set(n);
        wait_rel(9357.0);
        check("R2", meas_count, n, $sformatf("count for n=%0d", n));
        check("R5", lock_flag, exp_flag, $sformatf("hold n=%0d", n));
    endtask

    // R7: a runaway feedback clock saturates at 31 and is rejected.
    task automatic t_saturate();
        start_run(35);
        wait_rel(2957.0);
        check("R7", meas_count, 31, "saturated count");
        check("R7", lock_flag, 0, "no lock when saturated");
        start_run(14);
        wait_rel(2957.0);
        fb_set(35);
        wait_rel(9357.0);
        check("R7", meas_count, 31, "saturated count while locked");
        check("R7", lock_flag, 0, "drop when saturated");
    endtask

    // R6: stopped reference freezes flag and count in either state.
    task automatic t_ref_stop(input int n_first, input int n_after, input int exp_flag);
        start_run(n_first);
        wait_rel(2957.0);
        ref_on = 1'b0;
        fb_set(n_after);
        wait_rel(3.0 * 6400.0 + 2957.0);
        check("R6", lock_flag, exp_flag, $sformatf("flag frozen after n=%0d", n_first));
        check("R6", meas_count, n_first, $sformatf("count frozen at %0d", n_first));
        ref_on = 1'b1;
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #5_000_000;
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        t_reset_and_first();
        t_refresh_period();
        t_acquire(12, 0);
        t_acquire(13, 1);
        t_acquire(15, 1);
        t_acquire(16, 0);
        t_hold(10, 0);
        t_hold(11, 1);
        t_hold(17, 1);
        t_hold(18, 0);
        t_saturate();
        t_ref_stop(14, 30, 1);
        t_ref_stop(20, 14, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule